// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Monitor

This block holds the single reservation of one hart. A load-reserved request stores the block address of its operand and marks the reservation valid. A later store-conditional is allowed to write only if that reservation is still valid and covers the store's block. The monitor gates the memory write enable in the same cycle as the store-conditional. It reports the pass or fail result one cycle later.

Three sources can destroy the reservation: ordinary local loads and stores, writes from other agents reported on a snoop port, and an exceptional-event clear input. Addresses are compared only above log2 of a power-of-two block size. A `weak_mode` input selects one of two clearing rules. In strong mode only traffic inside the reserved block clears it. In weak mode any local access or any snooped write clears it.

Top module: `lrsc_monitor`

## Requirements
- R1: A store-conditional (op 2'b11) to the block of the last load-reserved (op 2'b10), with no clearing event between them, raises `mem_we` in its request cycle. It also gives `sc_ok`=1 in the next cycle.
- R2: Each store-conditional request causes `sc_done`=1 exactly one cycle later, and `sc_done`=0 in every other cycle. `sc_ok` is never 1 while `sc_done` is 0.
- R3: Addresses match on the bits above log2(`BLOCK_BYTES`), which is 64 bytes by default. A store-conditional to another byte of the reserved block succeeds. A store-conditional to a different block fails and keeps `mem_we` low.
- R4: In strong mode (`weak_mode`=0), the reservation is cleared by a local load (op 2'b00) or store (op 2'b01) inside the reserved block, and by a snooped write inside that block. The stored data does not matter. Traffic to other blocks leaves the reservation intact.
- R5: In weak mode (`weak_mode`=1), any local load or store, and any snooped write to any address, clears the reservation.
- R6: A pulse on `clear_evt` invalidates the reservation. A `clear_evt` in the same cycle as a store-conditional makes that store-conditional fail.
- R7: A second load-reserved replaces the reservation. Only the newest block can then succeed.
- R8: Every store-conditional consumes the reservation, whether it passes or fails. A following store-conditional fails unless a new load-reserved comes first.
- R9: A store-conditional with no valid reservation fails and keeps `mem_we` low.
- R10: A snooped write to the reserved block in the same cycle as a store-conditional makes the store-conditional fail.
- R11: Reset clears the reservation and drives `sc_done` and `sc_ok` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| weak_mode | input | 1 | 1 selects weak clearing rules |
| req_valid | input | 1 | Local request present |
| req_op | input | 2 | 00 load, 01 store, 10 load-reserved, 11 store-conditional |
| req_addr | input | ADDR_W | Local request byte address |
| snoop_valid | input | 1 | External write observed |
| snoop_addr | input | ADDR_W | External write byte address |
| clear_evt | input | 1 | Exception or context switch |
| mem_we | output | 1 | Memory write enable for the store-conditional |
| sc_done | output | 1 | Store-conditional result valid |
| sc_ok | output | 1 | Store-conditional succeeded |

## Verification
`mem_we` is combinational, so it is due in the cycle of the request. The bench drives each request at the falling edge and samples `mem_we` one time unit later. `sc_done` and `sc_ok` are registered, so they are due after the next rising edge. The bench samples them one time unit after that edge, before the next vector is driven. Each stimulus is therefore checked against its own results and never against a neighbour's.

// File: rtl/lrsc_monitor.sv
module lrsc_monitor #(
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              weak_mode,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic              clear_evt,
  output logic              mem_we,
  output logic              sc_done,
  output logic              sc_ok
);
  localparam int OFF   = $clog2(BLOCK_BYTES);
  localparam int BLK_W = ADDR_W - OFF;

  logic             rv_q;
  logic [BLK_W-1:0] rblk_q;

  wire [BLK_W-1:0] req_blk   = req_addr[ADDR_W-1:OFF];
  wire [BLK_W-1:0] snoop_blk = snoop_addr[ADDR_W-1:OFF];

  wire is_lr  = req_valid && req_op == 2'b10;
  wire is_sc  = req_valid && req_op == 2'b11;
  wire is_acc = req_valid && !req_op[1];

  wire req_hit   = rv_q && req_blk == rblk_q;
  wire snoop_hit = snoop_valid && (weak_mode || (rv_q && snoop_blk == rblk_q));
  wire snoop_new = snoop_valid && (weak_mode || snoop_blk == req_blk);
  wire acc_kill  = is_acc && (weak_mode || req_hit);

  assign mem_we = is_sc && req_hit && !snoop_hit && !clear_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rv_q    <= 1'b0;
      rblk_q  <= '0;
      sc_done <= 1'b0;
      sc_ok   <= 1'b0;
    end else begin
      sc_done <= is_sc;
      sc_ok   <= mem_we;
      if (clear_evt) rv_q <= 1'b0;
      else if (is_lr) begin
        rv_q   <= !snoop_new;
        rblk_q <= req_blk;
      end else if (is_sc || acc_kill || snoop_hit) rv_q <= 1'b0;
    end
  end

  // R1
  we_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (req_valid && req_op == 2'b11));
  // R2
  done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'b11) |=> sc_done);
  // R2
  ok_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sc_ok |-> sc_done);
  // R1
  we_to_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> sc_ok);
  // R8
  sc_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'b11) |=> !rv_q);
  // R6
  clear_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_evt |=> !rv_q);
  // R10
  snoop_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_valid && weak_mode) |-> !mem_we);
endmodule

// File: tb/lrsc_monitor_bench.sv
module lrsc_monitor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic weak_mode = 1'b0, req_valid = 1'b0, snoop_valid = 1'b0, clear_evt = 1'b0;
  logic [1:0] req_op = 2'b00;
  logic [AW-1:0] req_addr = '0, snoop_addr = '0;
  logic mem_we, sc_done, sc_ok;
  int compared = 0, mismatched = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lrsc_monitor u_lrsc_monitor (
    .clk(clk), .rst_n(rst_n), .weak_mode(weak_mode), .req_valid(req_valid),
    .req_op(req_op), .req_addr(req_addr), .snoop_valid(snoop_valid),
    .snoop_addr(snoop_addr), .clear_evt(clear_evt), .mem_we(mem_we),
    .sc_done(sc_done), .sc_ok(sc_ok));

  localparam logic [1:0] LD = 2'b00, ST = 2'b01, LR = 2'b10, SC = 2'b11;

  function automatic logic [39:0] mk(logic w, logic v, logic [1:0] op, logic [15:0] a,
                                     logic sv, logic [15:0] sa, logic c, logic we, logic ok);
    return {w, v, op, a, sv, sa, c, we, ok};
  endfunction

  localparam int NV = 37;
  localparam logic [39:0] VEC [NV] = '{
    mk(0,1,LR,16'h1000,0,0,0,0,0), mk(0,1,SC,16'h103C,0,0,0,1,1),
    mk(0,1,SC,16'h1000,0,0,0,0,0),
    mk(0,1,LR,16'h1000,0,0,0,0,0), mk(0,1,ST,16'h1008,0,0,0,0,0), mk(0,1,SC,16'h1000,0,0,0,0,0),
    mk(0,1,LR,16'h1000,0,0,0,0,0), mk(0,1,ST,16'h2000,0,0,0,0,0), mk(0,1,LD,16'h1040,0,0,0,0,0),
    mk(0,0,LD,16'h0000,1,16'h3000,0,0,0), mk(0,1,SC,16'h1000,0,0,0,1,1),
    mk(0,1,LR,16'h1000,0,0,0,0,0), mk(0,0,LD,16'h0000,1,16'h1020,0,0,0), mk(0,1,SC,16'h1000,0,0,0,0,0),
    mk(0,1,LR,16'h1000,0,0,0,0,0), mk(0,1,SC,16'h1040,0,0,0,0,0),
    mk(0,1,LR,16'h1000,0,0,0,0,0), mk(0,1,LR,16'h2000,0,0,0,0,0), mk(0,1,SC,16'h1000,0,0,0,0,0),
    mk(0,1,LR,16'h1000,0,0,0,0,0), mk(0,1,LR,16'h2000,0,0,0,0,0), mk(0,1,SC,16'h2004,0,0,0,1,1),
    mk(0,1,LR,16'h1000,0,0,0,0,0), mk(0,0,LD,16'h0000,0,0,1,0,0), mk(0,1,SC,16'h1000,0,0,0,0,0),
    mk(0,1,LR,16'h1000,0,0,0,0,0), mk(0,1,SC,16'h1000,1,16'h1010,0,0,0),
    mk(0,1,LR,16'h1000,0,0,0,0,0), mk(0,1,SC,16'h1000,1,16'h5000,0,1,1),
    mk(1,1,LR,16'h1000,0,0,0,0,0), mk(1,1,LD,16'h2000,0,0,0,0,0), mk(1,1,SC,16'h1000,0,0,0,0,0),
    mk(1,1,LR,16'h1000,0,0,0,0,0), mk(1,0,LD,16'h0000,1,16'h9000,0,0,0), mk(1,1,SC,16'h1000,0,0,0,0,0),
    mk(1,1,LR,16'h1000,0,0,0,0,0), mk(1,1,SC,16'h1000,0,0,0,1,1)
  };

  task automatic check(string req, logic act, logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(logic [39:0] v, string tag);
    logic issc;
    @(negedge clk);
    {weak_mode, req_valid, req_op} = v[39:36];
    req_addr = {16'h0, v[35:20]};
    snoop_valid = v[19];
    snoop_addr = {16'h0, v[18:3]};
    clear_evt = v[2];
    issc = v[38] && v[37:36] == SC;
    #1 check({tag, " mem_we"}, mem_we, v[1]);
    @(posedge clk); #1;
    check("R2 sc_done", sc_done, issc);
    if (issc) check({tag, " sc_ok"}, sc_ok, v[0]);
    @(negedge clk);
    req_valid = 0; snoop_valid = 0; clear_evt = 0;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1;
        check("R11 reset sc_done", sc_done, 1'b0);
        check("R11 reset sc_ok", sc_ok, 1'b0);
        @(negedge clk) rst_n = 1'b1;
        step(mk(0,1,SC,16'h1000,0,0,0,0,0), "R9 no reservation");
        for (int i = 0; i < NV; i++)
          step(VEC[i], "R1 R3 R4 R5 R6 R7 R8 R10 vector");
        step(mk(0,1,LR,16'h4000,0,0,0,0,0), "R11 pre");
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        step(mk(0,1,SC,16'h4000,0,0,0,0,0), "R11 after reset");
        step(mk(0,1,LR,16'h4000,0,0,0,0,0), "R6 pre");
        step(mk(0,1,SC,16'h4000,0,0,1,0,0), "R6 same-cycle clear");
      end
      begin
        repeat (5000) @(posedge clk);
        check("watchdog", 1'b1, 1'b0);
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule